// File: doc/BRIEF.md
# Cache-Line-Aware Write Command Selector

This block belongs to a bus-master DMA engine that stores received data in host memory. When a burst opens, it picks the bus command for that burst. The choice is a plain memory write (MW) or a memory write-and-invalidate (MWI). While the burst runs, the block follows the target dword address one data phase at a time. At each cache-line boundary it decides whether the burst must stop.

An MWI burst is allowed only when all of these hold:
- write-and-invalidate is enabled;
- the programmed line size is usable;
- the start address is line-aligned;
- both the free buffer space and the data waiting to be written cover at least one full line.

An MWI burst that loses any of these conditions is cut at the next line boundary. A plain-write burst is cut at each boundary if the cut-on-line option is set, so that the next burst can be chosen again and may be upgraded to MWI. With that option clear, a plain write runs across line boundaries. Every new burst has its command chosen afresh from the inputs present at that time.

Top module: `wr_cmd_sel`

## Requirements
- R1: During reset and in the first cycle after it, `burst_start`, `cut_request` and `cmd_is_mwi` are 0.
- R2: When no burst is open and `req_valid` is 1 at a clock edge, `burst_start` is 1 for exactly the following cycle. A burst is then open with `start_addr` as its current dword address.
- R3: At a burst start, `cmd_is_mwi` becomes 1 only when all of these were true at that edge; otherwise it becomes 0 (MW). It keeps that value until the next burst start.
  - `mwi_enable` is 1.
  - `line_size` is a nonzero power of two.
  - `start_addr` modulo `line_size` is 0.
  - `buf_space` is at least `line_size`.
  - `data_avail` is at least `line_size`.
- R4: A `line_size` of 0 never yields `cmd_is_mwi` = 1, whatever the other inputs are.
- R5: Each `beat_done` during an open burst with `req_valid` high advances the current address by one dword. A line boundary is reached when the advanced address modulo `line_size` is 0, with `line_size` a nonzero power of two.
- R6: In an MWI burst, a boundary at which the R3 conditions fail for the advanced address and the current buffer space and data count gives `cut_request` = 1 for one cycle and closes the burst. Otherwise the burst stays open.
- R7: In an MW burst with `cut_on_line` = 1, every boundary gives a one-cycle `cut_request` and closes the burst.
- R8: In an MW burst with `cut_on_line` = 0, boundaries give no `cut_request` and the burst stays open.
- R9: `req_valid` low at an edge during an open burst closes it without `cut_request`.
- R10: `beat_done` while no burst is open has no effect on any output.
- R11: `burst_start` and `cut_request` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Data is pending for host memory; keeps a burst open |
| start_addr | input | AW | Dword address at which a new burst would start |
| buf_space | input | SW | Free dwords left in the host buffer |
| data_avail | input | SW | Dwords ready to be written |
| line_size | input | LW | Cache line size in dwords; 0 disables MWI |
| mwi_enable | input | 1 | Write-and-invalidate allowed |
| cut_on_line | input | 1 | End plain-write bursts at line boundaries |
| beat_done | input | 1 | One data phase of the open burst completed |
| cmd_is_mwi | output | 1 | Command of the current/last burst: 1 MWI, 0 MW |
| burst_start | output | 1 | One-cycle strobe: a new burst opens |
| cut_request | output | 1 | One-cycle strobe: end the burst at this line boundary |

## Verification
The assertions assume that `req_valid`, `beat_done` and the configuration inputs are two-state and stable around the clock edge. They also assume that a `beat_done` stands for exactly one dword. The stimulus drives every input on the falling edge. It keeps the line size to 0, a non-power of two (3) or powers of two, and holds the configuration fixed over segments of several hundred cycles. Start addresses alternate between line-aligned and unaligned values, and space and data counts straddle one line, so that both commands and every cut path occur.

// File: rtl/wr_cmd_sel_pkg.sv
package wr_cmd_sel_pkg;

    typedef enum logic {
        CMD_MW  = 1'b0,
        CMD_MWI = 1'b1
    } wr_cmd_e;

    // A line size is usable when it is a nonzero power of two.
    function automatic logic line_usable(input logic [7:0] ls);
        return (ls != 8'd0) && ((ls & (ls - 8'd1)) == 8'd0);
    endfunction

endpackage

// File: rtl/line_edge.sv
module line_edge #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] line_size,
    output logic          usable,
    output logic          aligned
);
    localparam int XW = (AW > LW) ? AW : LW;

    logic [XW-1:0] ls_x;
    logic [XW-1:0] mask_x;
    logic [XW-1:0] addr_x;

    always_comb begin
        ls_x   = XW'(line_size);
        addr_x = XW'(addr);
        mask_x = ls_x - XW'(1);
        usable = (ls_x != '0) && ((ls_x & mask_x) == '0);
        aligned = usable && ((addr_x & mask_x) == '0);
    end
endmodule

// File: rtl/mwi_qualify.sv
module mwi_qualify #(
    parameter int AW = 16,
    parameter int SW = 12,
    parameter int LW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] space,
    input  logic [SW-1:0] avail,
    input  logic [LW-1:0] line_size,
    input  logic          enable,
    output logic          ok
);
    localparam int CW = (SW > LW) ? SW : LW;

    logic usable;
    logic aligned;

    line_edge #(.AW(AW), .LW(LW)) u_align (
        .addr      (addr),
        .line_size (line_size),
        .usable    (usable),
        .aligned   (aligned)
    );

    always_comb begin
        ok = enable && usable && aligned
             && (CW'(space) >= CW'(line_size))
             && (CW'(avail) >= CW'(line_size));
    end
endmodule

// File: rtl/wr_cmd_sel.sv
module wr_cmd_sel
    import wr_cmd_sel_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 12,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] start_addr,
    input  logic [SW-1:0] buf_space,
    input  logic [SW-1:0] data_avail,
    input  logic [LW-1:0] line_size,
    input  logic          mwi_enable,
    input  logic          cut_on_line,
    input  logic          beat_done,
    output logic          cmd_is_mwi,
    output logic          burst_start,
    output logic          cut_request
);
    typedef struct packed {
        logic          open;
        wr_cmd_e       cmd;
        logic [AW-1:0] addr;
        logic          start;
        logic          cut;
    } sel_state_t;

    sel_state_t st_q, st_d;

    logic [AW-1:0] addr_inc;
    logic          start_ok;
    logic          keep_ok;
    logic          edge_usable;
    logic          edge_hit;

    assign addr_inc = st_q.addr + AW'(1);

    mwi_qualify #(.AW(AW), .SW(SW), .LW(LW)) u_start_q (
        .addr      (start_addr),
        .space     (buf_space),
        .avail     (data_avail),
        .line_size (line_size),
        .enable    (mwi_enable),
        .ok        (start_ok)
    );

    mwi_qualify #(.AW(AW), .SW(SW), .LW(LW)) u_keep_q (
        .addr      (addr_inc),
        .space     (buf_space),
        .avail     (data_avail),
        .line_size (line_size),
        .enable    (mwi_enable),
        .ok        (keep_ok)
    );

    line_edge #(.AW(AW), .LW(LW)) u_edge (
        .addr      (addr_inc),
        .line_size (line_size),
        .usable    (edge_usable),
        .aligned   (edge_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.cut   = 1'b0;
        if (!st_q.open) begin
            if (req_valid) begin
                st_d.open  = 1'b1;
                st_d.start = 1'b1;
                st_d.cmd   = start_ok ? CMD_MWI : CMD_MW;
                st_d.addr  = start_addr;
            end
        end else if (!req_valid) begin
            st_d.open = 1'b0;
        end else if (beat_done) begin
            st_d.addr = addr_inc;
            if (edge_hit) begin
                if ((st_q.cmd == CMD_MWI) ? !keep_ok : cut_on_line) begin
                    st_d.cut  = 1'b1;
                    st_d.open = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{open: 1'b0, cmd: CMD_MW, addr: '0, start: 1'b0, cut: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_is_mwi  = (st_q.cmd == CMD_MWI);
    assign burst_start = st_q.start;
    assign cut_request = st_q.cut;

    // R11
    start_cut_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(burst_start && cut_request));

    // R3
    mwi_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_start && cmd_is_mwi) |-> $past(mwi_enable));

    // R4
    zero_line_no_mwi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_start && cmd_is_mwi) |-> $past(line_size != '0));

    // R7
    mw_cut_needs_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_request && !cmd_is_mwi) |-> $past(cut_on_line));

    // R6
    cut_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cut_request |-> ($past(beat_done) && $past(req_valid)));

    // R3
    cmd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_start && !$past(!rst_n)) |-> $stable(cmd_is_mwi));

    // R2
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !burst_start);
endmodule

// File: tb/wr_cmd_sel_bench.sv
module wr_cmd_sel_bench;
    localparam int AW = 16;
    localparam int SW = 12;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [SW-1:0] buf_space = '0;
    logic [SW-1:0] data_avail = '0;
    logic [LW-1:0] line_size = '0;
    logic          mwi_enable = 1'b0;
    logic          cut_on_line = 1'b0;
    logic          beat_done = 1'b0;
    logic          cmd_is_mwi;
    logic          burst_start;
    logic          cut_request;

    int checks = 0;
    int fails = 0;
    int seen_mwi = 0;
    int seen_cut = 0;

    // reference state
    logic          m_open = 1'b0;
    logic          m_mwi = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic          m_start = 1'b0;
    logic          m_cut = 1'b0;

    always #5 clk = ~clk;

    wr_cmd_sel #(.AW(AW), .SW(SW), .LW(LW)) u_wr_cmd_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .start_addr(start_addr),
        .buf_space(buf_space), .data_avail(data_avail), .line_size(line_size),
        .mwi_enable(mwi_enable), .cut_on_line(cut_on_line), .beat_done(beat_done),
        .cmd_is_mwi(cmd_is_mwi), .burst_start(burst_start), .cut_request(cut_request)
    );

    function automatic bit pow2(input int ls);
        return ls > 0 && (ls & (ls - 1)) == 0;
    endfunction

    function automatic bit may_mwi(input int a, input int sp, input int av,
                                   input int ls, input bit en);
        return en && pow2(ls) && (a % ls == 0) && sp >= ls && av >= ls;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_mwi = 0; m_addr = '0; m_start = 0; m_cut = 0;
        end else begin
            m_start = 0; m_cut = 0;
            if (!m_open) begin
                if (req_valid) begin
                    m_open = 1; m_start = 1; m_addr = start_addr;
                    m_mwi = may_mwi(int'(start_addr), int'(buf_space), int'(data_avail),
                                    int'(line_size), mwi_enable);
                end
            end else if (!req_valid) begin
                m_open = 0;
            end else if (beat_done) begin
                m_addr = m_addr + 1'b1;
                if (pow2(int'(line_size)) && (int'(m_addr) % int'(line_size) == 0)) begin
                    if (m_mwi ? !may_mwi(int'(m_addr), int'(buf_space), int'(data_avail),
                                         int'(line_size), mwi_enable) : cut_on_line) begin
                        m_cut = 1; m_open = 0;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(burst_start == m_start, "R2 burst_start", burst_start, m_start);
        check(cmd_is_mwi == m_mwi, "R3 cmd_is_mwi", cmd_is_mwi, m_mwi);
        check(cut_request == m_cut, "R6/R7/R8 cut_request", cut_request, m_cut);
        if (cmd_is_mwi) seen_mwi++;
        if (cut_request) seen_cut++;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic cfg(input int ls, input bit en, input bit cut, input int sp, input int av);
        line_size = LW'(ls); mwi_enable = en; cut_on_line = cut;
        buf_space = SW'(sp); data_avail = SW'(av);
    endtask

    initial begin : watchdog
        #1500000;
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        step();
        // R1 reset state
        check(!burst_start && !cut_request && !cmd_is_mwi, "R1 reset", {burst_start, cut_request, cmd_is_mwi}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!burst_start && !cut_request && !cmd_is_mwi, "R1 post-reset", {burst_start, cut_request, cmd_is_mwi}, 0);

        // R10: beats with no open burst change nothing
        beat_done = 1; step(); step();
        check(!burst_start && !cut_request, "R10 idle beats", {burst_start, cut_request}, 0);
        beat_done = 0;

        // R3 aligned start with enough space: MWI, then R6 cut when space runs short
        cfg(8, 1, 0, 64, 64); start_addr = 16'h0010; req_valid = 1;
        step();
        check(burst_start && cmd_is_mwi, "R3 aligned mwi", {burst_start, cmd_is_mwi}, 3);
        beat_done = 1;
        for (int i = 0; i < 7; i++) step();
        check(!cut_request, "R5 mid-line no cut", cut_request, 0);
        buf_space = SW'(4);
        step();
        check(cut_request, "R6 mwi cut at boundary", cut_request, 1);
        beat_done = 0;
        step();
        // R3 re-evaluation after cut: space short so MW now
        check(burst_start && !cmd_is_mwi, "R3 reselect mw", {burst_start, cmd_is_mwi}, 2);

        // R8 MW continues across boundary with cut_on_line clear
        beat_done = 1;
        for (int i = 0; i < 20; i++) step();
        check(seen_cut == 1, "R8 no cut across lines", seen_cut, 1);

        // R9 request drop closes burst quietly
        req_valid = 0; step();
        check(!cut_request, "R9 quiet close", cut_request, 0);
        beat_done = 0; step();

        // R7 MW with cut_on_line cuts at boundary
        cfg(4, 0, 1, 64, 64); start_addr = 16'h0001; req_valid = 1; beat_done = 0;
        step();
        check(burst_start && !cmd_is_mwi, "R3 mw when disabled", {burst_start, cmd_is_mwi}, 2);
        beat_done = 1; step(); step();
        check(!cut_request, "R7 before boundary", cut_request, 0);
        step();
        check(cut_request, "R7 mw cut", cut_request, 1);
        req_valid = 0; beat_done = 0; step(); step();

        // R4 line size zero never MWI
        cfg(0, 1, 1, 4000, 4000); start_addr = 16'h0000; req_valid = 1;
        step();
        check(burst_start && !cmd_is_mwi, "R4 zero line size", {burst_start, cmd_is_mwi}, 2);
        req_valid = 0; step(); step();

        // random segments
        for (int seg = 0; seg < 40; seg++) begin
            int pick = $urandom_range(0, 5);
            int ls = (pick == 0) ? 0 : (pick == 1) ? 3 : (4 << $urandom_range(0, 2));
            cfg(ls, $urandom_range(0, 3) != 0, $urandom_range(0, 1), 0, 0);
            for (int c = 0; c < 400; c++) begin
                req_valid  = $urandom_range(0, 9) != 0;
                beat_done  = $urandom_range(0, 3) != 0;
                start_addr = $urandom_range(0, 1) ? AW'($urandom_range(0, 255) * 16) : AW'($urandom);
                buf_space  = SW'($urandom_range(0, 40));
                data_avail = SW'($urandom_range(0, 40));
                step();
                // R11
                check(!(burst_start && cut_request), "R11 exclusive", {burst_start, cut_request}, 0);
            end
        end
        check(seen_mwi > 0 && seen_cut > 1, "R6 coverage", seen_cut, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule